// File: doc/BRIEF.md
# Configuration access address translator

This block sits between a CPU-side register slave and the slave address bus of a PCIe core. A CPU read or write that lands in a 64 KB configuration window is rewritten into the address form the core expects for a configuration cycle. The block also raises a flag that says whether the core should issue a type 0 or a type 1 request. A base register places the window. The window must sit on a 64 KB boundary, so only address bits 31:16 are compared.

The lower 32 KB of the window splits into eight 4 KB regions. Each region has its own 16-bit bus/device/function (BDF) register, and that register supplies the upper half of the translated address. Region 0 always yields type 0 requests. Every other region yields type 1. Software loads the BDF registers in pairs with 32-bit writes. It reads a pair back to make sure the write has landed before it issues the configuration access. An access outside the lower half of the window produces no core request and returns an error pulse. All results appear one clock after the CPU strobe.

Top module: `cfg_xlat`

## Requirements
- R1: After reset, core_valid_o, core_wr_o and cpu_err_o are 0, and the base and all BDF registers read back as zero.
- R2: A translated address is {BDF[15:0], 4'b0000, window offset bits 11:2, 2'b00}. Offset bits 15:12 and CPU address bits 1:0 never reach the core.
- R3: core_type1_o is 0 when window offset bits 15:12 are all zero, and 1 otherwise.
- R4: Window offset bits 14:12 select which of the eight BDF registers drives core address bits 31:16.
- R5: A 32-bit register write at offset 0x930 + 4*p (p = 0..3) loads BDF register 2p from write data bits 15:0 and BDF register 2p+1 from bits 31:16. A read at the same offset returns {BDF 2p+1, BDF 2p}.
- R6: A register write at offset 0x92C stores write data bits 31:16 as the window base. A read at that offset returns {base, 16'h0000}. CPU address bits 31:16 equal to the base select the window.
- R7: A CPU access outside the window, or in its upper half (offset bit 15 set), raises cpu_err_o for one cycle and leaves core_valid_o low.
- R8: Each accepted access raises core_valid_o exactly one cycle after the strobe. core_wr_o is 1 for writes and 0 for reads, core_wdata_o carries the CPU write data unchanged, and with no strobe both core_valid_o and cpu_err_o stay low.
- R9: A register write to any other offset changes no register, and a register read at an unmapped offset returns zero. Read data appears one cycle after reg_rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after reg_rd_i |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 32 | CPU byte address |
| cpu_wdata_i | input | 32 | CPU write data |
| core_valid_o | output | 1 | Configuration request valid |
| core_wr_o | output | 1 | Request is a write |
| core_type1_o | output | 1 | 1 for a type 1 request, 0 for a type 0 request |
| core_addr_o | output | 32 | Translated core address |
| core_wdata_o | output | 32 | Write data passed to the core |
| cpu_err_o | output | 1 | Error pulse for an access outside the usable window |

## Verification
The bench uses the default parameters: a 16-bit window, 12-bit regions and eight BDF registers. With these values, every region, both halves of the window and all four register pairs can be reached in a few hundred accesses. Random base values, BDF contents and offsets are mixed with directed cases at the region edges (0x0FFC, 0x1000, 0x7FFC, 0x8000, 0xFFFC) and one word below the window. Address bits 1:0 are varied so the test can show they are dropped.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BDF_W  = 16;

  typedef struct packed {
    logic              hit;
    logic              miss;
    logic              wr;
    logic              type1;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } xlat_req_t;
endpackage

// File: rtl/cfg_xlat_regs.sv
module cfg_xlat_regs
  import cfg_xlat_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned WIN_W       = 16,
  parameter int unsigned REG_AW      = 12,
  parameter int unsigned BASE_OFFS   = 32'h92C,
  parameter int unsigned BDF_OFFS    = 32'h930
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic                                rd_i,
  input  logic [REG_AW-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic [ADDR_W-WIN_W-1:0]             base_hi_o,
  output logic [NUM_REGIONS-1:0][BDF_W-1:0]   bdf_tbl_o
);
  localparam int unsigned NUM_PAIRS = NUM_REGIONS / 2;
  localparam int unsigned BASE_W    = ADDR_W - WIN_W;

  logic [BASE_W-1:0] base_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          base_q <= '0;
    else if (wr_i && addr_i == REG_AW'(BASE_OFFS))        base_q <= wdata_i[DATA_W-1 -: BASE_W];
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam logic [REG_AW-1:0] PAIR_OFFS = REG_AW'(BDF_OFFS + 4 * p);
    logic [2*BDF_W-1:0] pair_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         pair_q <= '0;
      else if (wr_i && addr_i == PAIR_OFFS) pair_q <= wdata_i[2*BDF_W-1:0];
    end
    assign bdf_tbl_o[2*p]   = pair_q[BDF_W-1:0];
    assign bdf_tbl_o[2*p+1] = pair_q[2*BDF_W-1:BDF_W];
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == REG_AW'(BASE_OFFS)) rd_mux = {base_q, {WIN_W{1'b0}}};
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (addr_i == REG_AW'(BDF_OFFS + 4 * p))
        rd_mux = DATA_W'({bdf_tbl_o[2*p+1], bdf_tbl_o[2*p]});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign base_hi_o = base_q;
endmodule

// File: rtl/cfg_xlat_decode.sv
module cfg_xlat_decode
  import cfg_xlat_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned WIN_W       = 16,
  parameter int unsigned REGION_W    = 12
) (
  input  logic                              rd_i,
  input  logic                              wr_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [ADDR_W-WIN_W-1:0]           base_hi_i,
  input  logic [NUM_REGIONS-1:0][BDF_W-1:0] bdf_tbl_i,
  output xlat_req_t                         req_o
);
  localparam int unsigned SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int unsigned GAP_W = WIN_W - REGION_W;

  logic [WIN_W-1:0] offs;
  logic [SEL_W-1:0] sel;
  logic             access, in_win;

  assign offs   = addr_i[WIN_W-1:0];
  assign sel    = offs[REGION_W +: SEL_W];
  assign access = rd_i | wr_i;
  // usable part is the lower half of an aligned window
  assign in_win = (addr_i[ADDR_W-1:WIN_W] == base_hi_i) && !offs[WIN_W-1];

  always_comb begin
    req_o       = '0;
    req_o.hit   = access & in_win;
    req_o.miss  = access & ~in_win;
    req_o.wr    = wr_i;
    req_o.type1 = |offs[WIN_W-1:REGION_W];
    req_o.addr  = {bdf_tbl_i[sel], {GAP_W{1'b0}}, offs[REGION_W-1:2], 2'b00};
    req_o.wdata = wdata_i;
  end
endmodule

// File: rtl/cfg_xlat_out.sv
module cfg_xlat_out
  import cfg_xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xlat_req_t         req_i,
  output logic              valid_o,
  output logic              wr_o,
  output logic              type1_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic valid_q, wr_q, type1_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= req_i.hit;
      wr_q    <= req_i.hit & req_i.wr;
      err_q   <= req_i.miss;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type1_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_i.hit) begin
      type1_q <= req_i.type1;
      addr_q  <= req_i.addr;
      wdata_q <= req_i.wdata;
    end
  end

  assign valid_o = valid_q;
  assign wr_o    = wr_q;
  assign type1_o = type1_q;
  assign err_o   = err_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/cfg_xlat.sv
module cfg_xlat
  import cfg_xlat_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned WIN_W       = 16,
  parameter int unsigned REGION_W    = 12,
  parameter int unsigned REG_AW      = 12,
  parameter int unsigned BASE_OFFS   = 32'h92C,
  parameter int unsigned BDF_OFFS    = 32'h930
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               cpu_rd_i,
  input  logic               cpu_wr_i,
  input  logic [31:0]        cpu_addr_i,
  input  logic [31:0]        cpu_wdata_i,
  output logic               core_valid_o,
  output logic               core_wr_o,
  output logic               core_type1_o,
  output logic [31:0]        core_addr_o,
  output logic [31:0]        core_wdata_o,
  output logic               cpu_err_o
);
  logic [ADDR_W-WIN_W-1:0]           base_hi;
  logic [NUM_REGIONS-1:0][BDF_W-1:0] bdf_tbl;
  xlat_req_t                         req;

  cfg_xlat_regs #(
    .NUM_REGIONS(NUM_REGIONS), .WIN_W(WIN_W), .REG_AW(REG_AW),
    .BASE_OFFS(BASE_OFFS), .BDF_OFFS(BDF_OFFS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .base_hi_o(base_hi), .bdf_tbl_o(bdf_tbl)
  );

  cfg_xlat_decode #(
    .NUM_REGIONS(NUM_REGIONS), .WIN_W(WIN_W), .REGION_W(REGION_W)
  ) u_dec (
    .rd_i(cpu_rd_i), .wr_i(cpu_wr_i), .addr_i(cpu_addr_i),
    .wdata_i(cpu_wdata_i), .base_hi_i(base_hi), .bdf_tbl_i(bdf_tbl),
    .req_o(req)
  );

  cfg_xlat_out u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req),
    .valid_o(core_valid_o), .wr_o(core_wr_o), .type1_o(core_type1_o),
    .err_o(cpu_err_o), .addr_o(core_addr_o), .wdata_o(core_wdata_o)
  );
endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk #(
  parameter int unsigned WIN_W    = 16,
  parameter int unsigned REGION_W = 12
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_rd_i,
  input logic        cpu_wr_i,
  input logic [31:0] cpu_addr_i,
  input logic [31:0] cpu_wdata_i,
  input logic        core_valid_o,
  input logic        core_wr_o,
  input logic        core_type1_o,
  input logic [31:0] core_addr_o,
  input logic [31:0] core_wdata_o,
  input logic        cpu_err_o
);
  assert_valid_err_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(core_valid_o && cpu_err_o));

  assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i || cpu_wr_i) == 1'b0 |=> !core_valid_o && !cpu_err_o);

  assert_wr_implies_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_o |-> core_valid_o);

  assert_wdata_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i |=> (core_valid_o || cpu_err_o) && (core_valid_o -> core_wdata_o == $past(cpu_wdata_i)));

  assert_unused_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> core_addr_o[WIN_W-1:REGION_W] == '0 && core_addr_o[1:0] == 2'b00);

  assert_type_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i || cpu_wr_i) |=> core_valid_o -> (core_type1_o == ($past(cpu_addr_i[WIN_W-1:REGION_W]) != '0)));

  assert_offs_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i || cpu_wr_i) |=> core_valid_o -> (core_addr_o[REGION_W-1:2] == $past(cpu_addr_i[REGION_W-1:2])));
endmodule

bind cfg_xlat cfg_xlat_chk #(.WIN_W(WIN_W), .REGION_W(REGION_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i),
  .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
  .core_valid_o(core_valid_o), .core_wr_o(core_wr_o), .core_type1_o(core_type1_o),
  .core_addr_o(core_addr_o), .core_wdata_o(core_wdata_o), .cpu_err_o(cpu_err_o)
);

// File: tb/cfg_xlat_tb_top.sv
module cfg_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        core_valid, core_wr, core_type1, cpu_err;
  logic [31:0] core_addr, core_wdata;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_base = '0;
  logic [15:0] m_bdf [8];

  always #4 clk = ~clk;

  cfg_xlat dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .core_valid_o(core_valid), .core_wr_o(core_wr),
    .core_type1_o(core_type1), .core_addr_o(core_addr),
    .core_wdata_o(core_wdata), .cpu_err_o(cpu_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] off);
    if (off == 12'h92C) return {m_base, 16'h0};
    for (int p = 0; p < 4; p++)
      if (off == 12'h930 + 12'(4 * p)) return {m_bdf[2*p+1], m_bdf[2*p]};
    return 32'h0;
  endfunction

  function automatic bit exp_hit(input logic [31:0] a);
    return a[31:16] == m_base && !a[15];
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] a);
    return {m_bdf[a[14:12]], 4'h0, a[11:2], 2'b00};
  endfunction

  task automatic reg_write(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (off == 12'h92C) m_base = d[31:16];
    for (int p = 0; p < 4; p++)
      if (off == 12'h930 + 12'(4 * p)) begin
        m_bdf[2*p] = d[15:0]; m_bdf[2*p+1] = d[31:16];
      end
  endtask

  task automatic reg_read(input logic [11:0] off, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = off;
    @(posedge clk); #1;
    chk(reg_rdata == exp_rd(off), req, 64'(reg_rdata), 64'(exp_rd(off)));
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic cpu_acc(input logic [31:0] a, input bit wr, input logic [31:0] d, input string req);
    bit h;
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; cpu_rd = !wr; cpu_wdata = d;
    h = exp_hit(a);
    @(posedge clk); #1;
    chk(core_valid == h, {req, " valid"}, 64'(core_valid), 64'(h));
    chk(cpu_err == !h, {req, " R7 err"}, 64'(cpu_err), 64'(!h));
    if (h) begin
      chk(core_addr == exp_addr(a), {req, " R2/R4 addr"}, 64'(core_addr), 64'(exp_addr(a)));
      chk(core_type1 == (a[15:12] != 4'h0), {req, " R3 type"}, 64'(core_type1), 64'(a[15:12] != 4'h0));
      chk(core_wr == wr, {req, " R8 wr"}, 64'(core_wr), 64'(wr));
      if (wr) chk(core_wdata == d, {req, " R8 wdata"}, 64'(core_wdata), 64'(d));
    end
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    @(posedge clk); #1;
    chk(!core_valid && !cpu_err, "R8 idle after strobe", 64'({core_valid, cpu_err}), 64'(0));
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_bdf[i] = '0;
    void'($urandom(32'h5EED_0123));
    #20 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(!core_valid && !core_wr && !cpu_err, "R1 outputs after reset", 64'({core_valid, core_wr, cpu_err}), 64'(0));
    reg_read(12'h92C, "R1 base reset");
    reg_read(12'h930, "R1 bdf reset");

    // R6 base register: low half dropped
    reg_write(12'h92C, 32'h4000_1234);
    reg_read(12'h92C, "R6 base readback");
    // R5 pairwise BDF load
    for (int p = 0; p < 4; p++) reg_write(12'h930 + 12'(4 * p), {4'(2*p+1), 12'hA5 + 12'(p), 4'(2*p), 12'h3C + 12'(p)});
    for (int p = 0; p < 4; p++) reg_read(12'h930 + 12'(4 * p), "R5 pair readback");

    // R2 R3 R4 region edges, R8 rd and wr
    cpu_acc(32'h4000_010F, 1'b0, 32'h0, "R3 region0 type0");
    cpu_acc(32'h4000_0FFC, 1'b1, 32'hDEAD_BEEF, "R2 region0 top");
    cpu_acc(32'h4000_1000, 1'b1, 32'h1234_5678, "R4 region1 base");
    cpu_acc(32'h4000_7FFE, 1'b0, 32'h0, "R4 region7 top");
    // R7 outside and upper half
    cpu_acc(32'h4000_8000, 1'b0, 32'h0, "R7 upper half start");
    cpu_acc(32'h4000_FFFC, 1'b1, 32'h1, "R7 upper half end");
    cpu_acc(32'h3FFF_FFFC, 1'b0, 32'h0, "R7 below window");
    cpu_acc(32'h4001_0000, 1'b1, 32'h2, "R7 above window");

    // R9 unmapped writes ignored, unmapped read zero
    reg_write(12'h940, 32'hFFFF_FFFF);
    reg_write(12'h92E, 32'hFFFF_FFFF);
    reg_write(12'h000, 32'hFFFF_FFFF);
    reg_read(12'h940, "R9 unmapped read");
    reg_read(12'h92C, "R9 base untouched");
    for (int p = 0; p < 4; p++) reg_read(12'h930 + 12'(4 * p), "R9 pair untouched");
    cpu_acc(32'h4000_3004, 1'b0, 32'h0, "R9 translation untouched");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned r = $urandom;
      if (r % 16 == 0) reg_write(12'h92C, $urandom);
      else if (r % 16 == 1) reg_write(12'h930 + 12'(4 * ($urandom % 4)), $urandom);
      else if (r % 16 == 2) reg_read(12'h930 + 12'(4 * ($urandom % 4)), "R5 random readback");
      else begin
        logic [31:0] a;
        a = {(r % 8 == 3) ? 16'($urandom) : m_base, 16'($urandom)};
        cpu_acc(a, r[8], $urandom, "R8 random access");
      end
    end
    finish_run();
  end
endmodule